// File: doc/BRIEF.md
# Fragment-List DMA Encrypt Sequencer

This block runs one encrypt job over a list of buffers in host memory. While idle it is a register target. The host programs a descriptor address and issues a start command. The block then becomes bus master and fetches a descriptor table into local storage. It reads every plaintext fragment in table order through a 32-bit memory master port. It passes each word through an external cipher stream port and writes the ciphertext back over the plaintext at the same addresses. The cipher stream uses a valid/ready handshake.

As it writes ciphertext, the block keeps a 16-bit ones-complement checksum for each fragment. It also folds each fragment checksum into a job total. When the job ends it raises a sticky interrupt and drops back to target mode, and the host then reads the checksums through the register port. A fragment longer than the staging buffers is handled in several read/cipher/write rounds of at most `BUF_WORDS` words each.

Top module: `frag_dma_seq`

## Requirements
- R1: After reset, and whenever no job is running, `master_o` is low, `irq_o` is low after reset, and `mem_req_o` is never raised; the status register (word 2) reads `{busy_err, fmt_err, irq, master}` in bits 3..0.
- R2: Writing bit 0 of the control register (word 0) while in target mode raises `master_o`. The block then reads the descriptor header from the byte address held in the base register (word 1). Every memory request is held with a stable address until `mem_gnt_i`, and read data returns later on `mem_rvalid_i`.
- R3: The descriptor is a header word with cipher select in bits 15:12 and fragment count in bits 11:0. For each fragment it is followed by a byte-address word and then a byte-length word, at consecutive word addresses after the header.
- R4: Each fragment word is replaced in host memory by the cipher output for that word, with fragments handled in table order. `cip_sel_o` carries the header's cipher select and does not change while words are offered.
- R5: The checksum of fragment k is the 16-bit ones-complement sum, with end-around carry, of all its ciphertext halfwords (high half then low half of each word), starting from zero. It is readable at register word 0x80+k. A zero-length fragment has checksum 0.
- R6: The total (register word 3) is the ones-complement sum of all fragment checksums of the job, and it is 0 for a job with zero fragments.
- R7: A fragment longer than `BUF_WORDS` words is processed in consecutive rounds of at most `BUF_WORDS` words, and its result is the same as for a short fragment.
- R8: If any fragment length is not a multiple of 16 bytes, or the count exceeds `MAX_FRAGS`, the job aborts before any memory write. Status bit 2 is set and the interrupt is raised.
- R9: The interrupt stays high until the host writes bit 1 of the control register. That write also clears both error flags.
- R10: A start command while `master_o` is high is ignored: the running job completes unchanged, and status bit 3 is set.
- R11: Checksum and total reads return 0 while `master_o` is high. Checksum storage is written only while `master_o` is high.
- R12: At job end the block drops `master_o` in the same cycle that `irq_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; data valid the next cycle |
| reg_addr_i | input | 8 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| irq_o | output | 1 | Sticky completion interrupt |
| master_o | output | 1 | High while the block owns the memory port |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| cip_sel_o | output | 4 | Cipher select |
| cip_in_valid_o | output | 1 | Plaintext word valid |
| cip_in_data_o | output | 32 | Plaintext word |
| cip_in_ready_i | input | 1 | Cipher accepts plaintext |
| cip_out_valid_i | input | 1 | Ciphertext word valid |
| cip_out_data_i | input | 32 | Ciphertext word |
| cip_out_ready_o | output | 1 | Block accepts ciphertext |

## Verification
The bench places fragments at falling addresses. A design that sorted by address, or that stored checksums by completion order, would put checksums in the wrong slots. It runs a 12-word fragment against 8-word staging buffers plus a zero-length fragment. A wrong chunk split or pointer advance would corrupt words past the first round, and an off-by-one would hang on the empty fragment. It sends a bad length as the last table entry, where a design that checked lengths too late would already have written ciphertext. It also issues a second start mid-job and reads checksums while the job runs. A design that restarted or exposed half-built sums would show wrong data or a nonzero read.

// File: rtl/fdma_pkg.sv
package fdma_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR_REQ, S_HDR_WAIT, S_DSC_REQ, S_DSC_WAIT, S_FRAG, S_CHUNK,
    S_RD_REQ, S_RD_WAIT, S_CIPH, S_WR, S_NEXT, S_ABORT, S_DONE
  } fdma_state_e;

  // 16-bit ones-complement add with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

endpackage

// File: rtl/fdma_ram.sv
module fdma_ram #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/fdma_csum_store.sv
module fdma_csum_store import fdma_pkg::*; #(
  parameter int unsigned MAX_FRAGS = 16,
  localparam int unsigned FIW = (MAX_FRAGS > 1) ? $clog2(MAX_FRAGS) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           master_i,
  input  logic           clear_i,
  input  logic           we_i,
  input  logic [FIW-1:0] idx_i,
  input  logic [15:0]    sum_i,
  input  logic [FIW-1:0] rd_idx_i,
  output logic [15:0]    rd_sum_o,
  output logic [15:0]    total_o
);
  logic [15:0] sums [MAX_FRAGS];
  logic [15:0] total_q;

  always_ff @(posedge clk_i) begin
    if (we_i) sums[idx_i] <= sum_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      total_q <= '0;
    else if (clear_i) total_q <= '0;
    else if (we_i)    total_q <= oc_add(total_q, sum_i);
  end

  // host view is blanked while the job owns the storage
  assign rd_sum_o = master_i ? 16'd0 : sums[rd_idx_i];
  assign total_o  = master_i ? 16'd0 : total_q;

  assert_csum_wr_master_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> master_i);
endmodule

// File: rtl/fdma_ctrl.sv
module fdma_ctrl import fdma_pkg::*; #(
  parameter int unsigned BUF_WORDS = 512,
  parameter int unsigned MAX_FRAGS = 16,
  localparam int unsigned FIW = (MAX_FRAGS > 1) ? $clog2(MAX_FRAGS) : 1,
  localparam int unsigned BAW = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1,
  localparam int unsigned NW  = BAW + 1,
  localparam int unsigned DW  = FIW + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [31:0]    base_i,
  output logic           master_o,
  output logic           done_o,
  output logic           err_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [31:0]    mem_addr_o,
  output logic [31:0]    mem_wdata_o,
  input  logic           mem_gnt_i,
  input  logic           mem_rvalid_i,
  input  logic [31:0]    mem_rdata_i,
  output logic [3:0]     cip_sel_o,
  output logic           cip_in_valid_o,
  output logic [31:0]    cip_in_data_o,
  input  logic           cip_in_ready_i,
  input  logic           cip_out_valid_i,
  input  logic [31:0]    cip_out_data_i,
  output logic           cip_out_ready_o,
  output logic           csum_we_o,
  output logic [FIW-1:0] csum_idx_o,
  output logic [15:0]    csum_val_o
);
  localparam logic [NW-1:0] BUF_N = NW'(BUF_WORDS);

  fdma_state_e st_q;
  logic [31:0]   base_q, addr_q, fa_tmp_q;
  logic [11:0]   cnt_q;
  logic [3:0]    sel_q;
  logic [DW-1:0] didx_q;
  logic [FIW:0]  frag_q;
  logic [29:0]   rem_q;
  logic [NW-1:0] n_q, i_q, fi_q, oi_q;
  logic [15:0]   csum_q;

  logic [59:0]   dsc_rdata;
  logic [31:0]   rbuf_rdata, wbuf_rdata;
  logic          in_fire, out_fire, dsc_last;

  fdma_ram #(.W(60), .DEPTH(MAX_FRAGS)) u_dsc (
    .clk_i, .we_i(st_q == S_DSC_WAIT && mem_rvalid_i && didx_q[0]),
    .waddr_i(didx_q[FIW:1]), .wdata_i({fa_tmp_q, mem_rdata_i[31:4]}),
    .raddr_i(frag_q[FIW-1:0]), .rdata_o(dsc_rdata));

  fdma_ram #(.W(32), .DEPTH(BUF_WORDS)) u_rbuf (
    .clk_i, .we_i(st_q == S_RD_WAIT && mem_rvalid_i),
    .waddr_i(i_q[BAW-1:0]), .wdata_i(mem_rdata_i),
    .raddr_i(fi_q[BAW-1:0]), .rdata_o(rbuf_rdata));

  fdma_ram #(.W(32), .DEPTH(BUF_WORDS)) u_wbuf (
    .clk_i, .we_i(out_fire),
    .waddr_i(oi_q[BAW-1:0]), .wdata_i(cip_out_data_i),
    .raddr_i(i_q[BAW-1:0]), .rdata_o(wbuf_rdata));

  assign master_o        = (st_q != S_IDLE);
  assign done_o          = (st_q == S_DONE) || (st_q == S_ABORT);
  assign err_o           = (st_q == S_ABORT);
  assign cip_sel_o       = sel_q;
  assign cip_in_valid_o  = (st_q == S_CIPH) && (fi_q != n_q);
  assign cip_in_data_o   = rbuf_rdata;
  assign cip_out_ready_o = (st_q == S_CIPH) && (oi_q != n_q);
  assign in_fire         = cip_in_valid_o && cip_in_ready_i;
  assign out_fire        = cip_out_valid_i && cip_out_ready_o;
  assign csum_we_o       = (st_q == S_NEXT);
  assign csum_idx_o      = frag_q[FIW-1:0];
  assign csum_val_o      = csum_q;
  assign dsc_last        = (13'(didx_q) + 13'd1) == {cnt_q, 1'b0};

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = wbuf_rdata;
    unique case (st_q)
      S_HDR_REQ: begin mem_req_o = 1'b1; mem_addr_o = base_q; end
      S_DSC_REQ: begin mem_req_o = 1'b1; mem_addr_o = base_q + ((32'(didx_q) + 32'd1) << 2); end
      S_RD_REQ:  begin mem_req_o = 1'b1; mem_addr_o = addr_q + (32'(i_q) << 2); end
      S_WR: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = addr_q + (32'(i_q) << 2);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; base_q <= '0; addr_q <= '0; fa_tmp_q <= '0;
      cnt_q <= '0; sel_q <= '0; didx_q <= '0; frag_q <= '0; rem_q <= '0;
      n_q <= '0; i_q <= '0; fi_q <= '0; oi_q <= '0; csum_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin base_q <= base_i; st_q <= S_HDR_REQ; end
        S_HDR_REQ: if (mem_gnt_i) st_q <= S_HDR_WAIT;
        S_HDR_WAIT: if (mem_rvalid_i) begin
          sel_q  <= mem_rdata_i[15:12];
          cnt_q  <= mem_rdata_i[11:0];
          didx_q <= '0;
          frag_q <= '0;
          if (32'(mem_rdata_i[11:0]) > MAX_FRAGS) st_q <= S_ABORT;
          else if (mem_rdata_i[11:0] == 12'd0)    st_q <= S_DONE;
          else                                    st_q <= S_DSC_REQ;
        end
        S_DSC_REQ: if (mem_gnt_i) st_q <= S_DSC_WAIT;
        S_DSC_WAIT: if (mem_rvalid_i) begin
          didx_q <= didx_q + 1'b1;
          if (!didx_q[0]) begin
            fa_tmp_q <= mem_rdata_i;
            st_q     <= S_DSC_REQ;
          end else if (mem_rdata_i[3:0] != 4'd0) st_q <= S_ABORT;
          else if (dsc_last)                      st_q <= S_FRAG;
          else                                    st_q <= S_DSC_REQ;
        end
        S_FRAG: begin
          addr_q <= dsc_rdata[59:28];
          rem_q  <= {dsc_rdata[27:0], 2'b00};
          csum_q <= '0;
          st_q   <= S_CHUNK;
        end
        S_CHUNK: begin
          i_q <= '0;
          if (rem_q == '0) st_q <= S_NEXT;
          else begin
            n_q  <= (rem_q >= 30'(BUF_WORDS)) ? BUF_N : rem_q[NW-1:0];
            st_q <= S_RD_REQ;
          end
        end
        S_RD_REQ: if (mem_gnt_i) st_q <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rvalid_i) begin
          i_q <= i_q + 1'b1;
          if (i_q + 1'b1 == n_q) begin
            fi_q <= '0; oi_q <= '0; st_q <= S_CIPH;
          end else st_q <= S_RD_REQ;
        end
        S_CIPH: begin
          if (in_fire)  fi_q <= fi_q + 1'b1;
          if (out_fire) oi_q <= oi_q + 1'b1;
          if (oi_q == n_q) begin i_q <= '0; st_q <= S_WR; end
        end
        S_WR: if (mem_gnt_i) begin
          csum_q <= oc_add(oc_add(csum_q, wbuf_rdata[31:16]), wbuf_rdata[15:0]);
          i_q    <= i_q + 1'b1;
          if (i_q + 1'b1 == n_q) begin
            addr_q <= addr_q + (32'(n_q) << 2);
            rem_q  <= rem_q - 30'(n_q);
            st_q   <= S_CHUNK;
          end
        end
        S_NEXT: begin
          frag_q <= frag_q + 1'b1;
          st_q   <= (12'(frag_q) + 12'd1 == cnt_q) ? S_DONE : S_FRAG;
        end
        S_ABORT: st_q <= S_IDLE;
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_buf_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_CIPH) |-> (fi_q <= n_q) && (oi_q <= n_q) && (n_q <= BUF_N));

  assert_sel_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cip_in_valid_o |-> $stable(cip_sel_o));
endmodule

// File: rtl/frag_dma_seq.sv
module frag_dma_seq #(
  parameter int unsigned BUF_WORDS = 512,
  parameter int unsigned MAX_FRAGS = 16,
  localparam int unsigned FIW = (MAX_FRAGS > 1) ? $clog2(MAX_FRAGS) : 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o,
  output logic        master_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_gnt_i,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic [3:0]  cip_sel_o,
  output logic        cip_in_valid_o,
  output logic [31:0] cip_in_data_o,
  input  logic        cip_in_ready_i,
  input  logic        cip_out_valid_i,
  input  logic [31:0] cip_out_data_i,
  output logic        cip_out_ready_o
);
  logic [31:0]    base_q;
  logic           irq_q, fmt_err_q, busy_err_q;
  logic           start_cmd, clr_cmd, start_go, done, err;
  logic           csum_we;
  logic [FIW-1:0] csum_idx;
  logic [15:0]    csum_val, rd_sum, total;

  assign start_cmd = reg_wr_i && (reg_addr_i == 8'h00) && reg_wdata_i[0];
  assign clr_cmd   = reg_wr_i && (reg_addr_i == 8'h00) && reg_wdata_i[1];
  assign start_go  = start_cmd && !master_o;

  fdma_ctrl #(.BUF_WORDS(BUF_WORDS), .MAX_FRAGS(MAX_FRAGS)) u_ctrl (
    .clk_i, .rst_ni, .start_i(start_go), .base_i(base_q),
    .master_o, .done_o(done), .err_o(err),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .cip_sel_o, .cip_in_valid_o, .cip_in_data_o, .cip_in_ready_i,
    .cip_out_valid_i, .cip_out_data_i, .cip_out_ready_o,
    .csum_we_o(csum_we), .csum_idx_o(csum_idx), .csum_val_o(csum_val));

  fdma_csum_store #(.MAX_FRAGS(MAX_FRAGS)) u_csum (
    .clk_i, .rst_ni, .master_i(master_o), .clear_i(start_go),
    .we_i(csum_we), .idx_i(csum_idx), .sum_i(csum_val),
    .rd_idx_i(reg_addr_i[FIW-1:0]), .rd_sum_o(rd_sum), .total_o(total));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0; irq_q <= 1'b0; fmt_err_q <= 1'b0; busy_err_q <= 1'b0;
    end else begin
      if (reg_wr_i && reg_addr_i == 8'h01 && !master_o) base_q <= reg_wdata_i;
      if (clr_cmd) begin irq_q <= 1'b0; fmt_err_q <= 1'b0; busy_err_q <= 1'b0; end
      if (start_go) fmt_err_q <= 1'b0;
      if (start_cmd && master_o) busy_err_q <= 1'b1;
      if (done) begin
        irq_q <= 1'b1;
        if (err) fmt_err_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_rdata_o <= '0;
    else if (reg_rd_i) begin
      if (reg_addr_i[7]) begin
        reg_rdata_o <= (32'(reg_addr_i[6:0]) < MAX_FRAGS) ? {16'd0, rd_sum} : '0;
      end else begin
        unique case (reg_addr_i[6:0])
          7'h01:   reg_rdata_o <= base_q;
          7'h02:   reg_rdata_o <= {28'd0, busy_err_q, fmt_err_q, irq_q, master_o};
          7'h03:   reg_rdata_o <= {16'd0, total};
          default: reg_rdata_o <= '0;
        endcase
      end
    end
  end

  assign irq_o = irq_q;

  assert_irq_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !clr_cmd |=> irq_q);

  assert_done_irq_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(master_o) |-> irq_q);

  assert_busy_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_cmd && master_o && !clr_cmd |=> busy_err_q && master_o);
endmodule

// File: tb/sim_frag_dma_seq.sv
`timescale 1ns/1ps
module sim_frag_dma_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, master, mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  sel;
  logic        cin_v, cin_r, cout_v, cout_r;
  logic [31:0] cin_d, cout_d;

  int n_chk = 0, n_bad = 0, idle_req = 0, cyc = 0;
  logic [31:0] mem [256];
  logic [31:0] snap [256];
  logic        bd_we = 1'b0;
  logic [7:0]  bd_a = '0;
  logic [31:0] bd_d = '0;
  logic [1:0]  gcnt = '0;
  logic        go = 1'b0;

  always #4 clk = ~clk;

  frag_dma_seq #(.BUF_WORDS(8), .MAX_FRAGS(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .master_o(master), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .cip_sel_o(sel),
    .cip_in_valid_o(cin_v), .cip_in_data_o(cin_d), .cip_in_ready_i(cin_r),
    .cip_out_valid_i(cout_v), .cip_out_data_i(cout_d), .cip_out_ready_o(cout_r));

  function automatic logic [31:0] key(input logic [3:0] s);
    return {28'h5AC30F0, s};
  endfunction

  function automatic int ocs(input int a, input int b);
    int s;
    s = a + b;
    if (s > 65535) s = s - 65535;
    return s;
  endfunction

  // cipher stub with periodic stalls
  assign cin_r  = cout_r & go;
  assign cout_v = cin_v & go;
  assign cout_d = cin_d ^ key(sel);

  // memory model: grant on 3 of 4 cycles, read data one cycle after grant
  assign mem_gnt = mem_req && (gcnt != 2'd0);
  always @(posedge clk) begin
    cyc    <= cyc + 1;
    go     <= ~go;
    gcnt   <= gcnt + 2'd1;
    mem_rvalid <= mem_req && mem_gnt && !mem_we;
    mem_rdata  <= mem[mem_addr[9:2]];
    if (mem_req && mem_gnt && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (bd_we) mem[bd_a] <= bd_d;
    if (!master && mem_req) idle_req <= idle_req + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(input int byte_a, input logic [31:0] d);
    @(negedge clk); bd_we = 1'b1; bd_a = 8'(byte_a >> 2); bd_d = d;
    @(negedge clk); bd_we = 1'b0;
  endtask

  task automatic fill(input int byte_a, input int words);
    for (int k = 0; k < words; k++)
      poke(byte_a + 4*k, (32'(byte_a + 4*k) * 32'h9E3779B1) ^ 32'h00001234);
  endtask

  task automatic hwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  // start a job at base, wait for it, check everything derivable from the table
  task automatic run_job(input int base, input bit poke_busy);
    logic [31:0] w0, st, r;
    int cnt, fa, fl, cs, tot, wds;
    bit bad;
    logic [3:0] s;
    w0  = mem[base >> 2];
    cnt = int'(w0[11:0]);
    s   = w0[15:12];
    bad = (cnt > 4);
    if (!bad)
      for (int k = 0; k < cnt; k++) if (mem[(base >> 2) + 2 + 2*k][3:0] != 0) bad = 1;
    for (int k = 0; k < 256; k++) snap[k] = mem[k];
    hwr(8'h01, 32'(base));
    hwr(8'h00, 32'h2);
    hwr(8'h00, 32'h1);
    if (poke_busy) begin
      chk(master == 1'b1, "R2", int'(master), 1);
      hwr(8'h00, 32'h1);
      hrd(8'h02, st);
      chk(st[3] == 1'b1, "R10", int'(st), 8);
      hrd(8'h80, r);
      chk(r == 32'd0, "R11", int'(r), 0);
      hrd(8'h03, r);
      chk(r == 32'd0, "R11", int'(r), 0);
    end
    for (int t = 0; t < 20000 && !irq; t++) @(negedge clk);
    chk(irq == 1'b1, "R12", int'(irq), 1);
    chk(master == 1'b0, "R12", int'(master), 0);
    hrd(8'h02, st);
    chk(st[2] == bad, "R8", int'(st[2]), int'(bad));
    chk(st[3] == poke_busy, "R10", int'(st[3]), int'(poke_busy));
    if (bad) begin
      wds = 0;
      for (int k = 0; k < 256; k++) if (mem[k] !== snap[k]) wds++;
      chk(wds == 0, "R8", wds, 0);
    end else begin
      tot = 0;
      for (int k = 0; k < cnt; k++) begin
        fa = int'(mem[(base >> 2) + 1 + 2*k]);
        fl = int'(mem[(base >> 2) + 2 + 2*k]);
        cs = 0;
        for (int j = 0; j < fl/4; j++) begin
          logic [31:0] e;
          e  = snap[(fa >> 2) + j] ^ key(s);
          chk(mem[(fa >> 2) + j] == e, fl > 32 ? "R7" : "R4", int'(mem[(fa >> 2) + j]), int'(e));
          cs = ocs(ocs(cs, int'(e[31:16])), int'(e[15:0]));
        end
        hrd(8'h80 + 8'(k), r);
        chk(r == 32'(cs), "R5", int'(r), cs);
        tot = ocs(tot, cs);
      end
      hrd(8'h03, r);
      chk(r == 32'(tot), "R6", int'(r), tot);
    end
  endtask

  task automatic t_reset();
    logic [31:0] r;
    chk(irq == 1'b0, "R1", int'(irq), 0);
    chk(master == 1'b0, "R1", int'(master), 0);
    chk(mem_req == 1'b0, "R1", int'(mem_req), 0);
    hrd(8'h02, r);
    chk(r == 32'd0, "R1", int'(r), 0);
  endtask

  task automatic t_basic();   // falling addresses, R3 layout
    poke(32'h000, 32'h3002);
    poke(32'h004, 32'h200); poke(32'h008, 32'd16);
    poke(32'h00C, 32'h100); poke(32'h010, 32'd32);
    fill(32'h100, 8); fill(32'h200, 4);
    run_job(32'h000, 1'b0);
  endtask

  task automatic t_chunk();   // 12 words over 8-word buffers, then empty fragment
    poke(32'h040, 32'h5002);
    poke(32'h044, 32'h300); poke(32'h048, 32'd48);
    poke(32'h04C, 32'h380); poke(32'h050, 32'd0);
    fill(32'h300, 12);
    run_job(32'h040, 1'b0);
  endtask

  task automatic t_busy();
    run_job(32'h000, 1'b1);
  endtask

  task automatic t_badlen();  // second length not a multiple of 16
    poke(32'h080, 32'h1002);
    poke(32'h084, 32'h100); poke(32'h088, 32'd16);
    poke(32'h08C, 32'h200); poke(32'h090, 32'd20);
    run_job(32'h080, 1'b0);
  endtask

  task automatic t_toomany();
    poke(32'h0A0, 32'h1005);
    run_job(32'h0A0, 1'b0);
  endtask

  task automatic t_zero();
    poke(32'h0C0, 32'h7000);
    run_job(32'h0C0, 1'b0);
  endtask

  task automatic t_irq();
    logic [31:0] r;
    repeat (20) @(negedge clk);
    chk(irq == 1'b1, "R9", int'(irq), 1);
    hwr(8'h00, 32'h2);
    chk(irq == 1'b0, "R9", int'(irq), 0);
    hrd(8'h02, r);
    chk(r == 32'd0, "R9", int'(r), 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_irq();
    t_chunk();
    t_busy();
    t_badlen();
    t_toomany();
    t_zero();
    t_irq();
    chk(idle_req == 0, "R1", idle_req, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule